// File: doc/BRIEF.md
# Serial Status Register Command Unit

This block is the serial slave front end that owns the status byte of a serial memory. A host selects it with an active-low select line and clocks commands in mode 0: it samples data on the rising clock edge and changes the output on the falling edge. The block decodes three opcodes: read status, write status and set write enable. It returns the status byte on the serial output and updates the writable protection fields. It keeps a write-enable latch and reflects an external busy flag, which marks an internal store or recall cycle in progress.

All serial lines are sampled in the system clock domain through a synchronizer. A command takes effect only when select rises after the exact number of serial clocks that the command calls for. The two block-protect bits and the write-protect-enable bit drive outputs that a neighbouring protection decoder can use.

Top module: `spi_status_unit`

## Requirements
- R1: After reset the protection bits, write-protect enable and the write-enable latch are 0, and the output enable is low.
- R2: Opcode 0x05, sent MSB first, returns the status byte MSB first: bit 7 = write-protect enable, bits 6..4 = 0, bit 3 = block-protect 1, bit 2 = block-protect 0, bit 1 = write-enable latch, bit 0 = busy.
- R3: The serial output enable stays low while the opcode is shifted in and while select is high. It is high only during the data phase of a read-status command.
- R4: Opcode 0x06 with exactly 8 serial clocks sets the write-enable latch.
- R5: Opcode 0x01 followed by a data byte, with exactly 16 clocks and the latch set, copies data bit 7 to write-protect enable and data bits 3..2 to the block-protect bits. Data bits 6..4 and 1..0 are ignored.
- R6: A write-status command issued while the write-enable latch is 0 changes nothing.
- R7: A write-status frame that is not exactly 16 clocks long, or a write-enable frame that is not exactly 8 clocks long, changes no state, including the latch.
- R8: Every complete 16-clock write-status frame clears the write-enable latch, whether or not the write was accepted.
- R9: When write-protect enable is 1 and the write-protect pin is low, a write-status command is refused. When write-protect enable is 0, the pin has no effect.
- R10: Status bit 0 follows the busy input and cannot be written.
- R11: The block-protect and write-protect-enable outputs equal the stored bits and change only at the end of a frame.
- R12: Continued clocking in a read-status command sends the status byte again for every further 8 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial select, active low |
| sck | input | 1 | Serial clock, mode 0 |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out |
| miso_oe | output | 1 | Output enable for the serial data out driver |
| wp_n | input | 1 | Write-protect pin, active low |
| busy | input | 1 | High while a store or recall cycle runs |
| bp | output | 2 | Block-protect level |
| wpe | output | 1 | Write-protect enable |

## Verification
The assertions assume that the serial clock is much slower than the system clock, so that every serial edge appears as a distinct synchronized pulse. They also assume that select changes only while the serial clock is low. The stimulus holds each serial level for eight system clocks and moves select only with the serial clock idle low. The write-protect pin and busy change only between frames, so a refused or accepted commit never depends on a pin changing at the moment select rises.

// File: rtl/spi_sr_pkg.sv
package spi_sr_pkg;
  localparam logic [7:0] OP_READ_STAT  = 8'h05;
  localparam logic [7:0] OP_WRITE_STAT = 8'h01;
  localparam logic [7:0] OP_SET_WEL    = 8'h06;

  // Writable fields arrive as {wpe, bp1, bp0}
  typedef struct packed {
    logic       wpe;
    logic [1:0] bp;
  } prot_t;

  function automatic logic [7:0] pack_status(prot_t p, logic wel, logic busy);
    return {p.wpe, 3'b000, p.bp, wel, busy};
  endfunction
endpackage

// File: rtl/spi_sr_sync.sv
module spi_sr_sync #(
  parameter int          WIDTH     = 1,
  parameter int          STAGES    = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] src;
    if (s == 0) begin : g_first
      assign src = d_i;
    end else begin : g_next
      assign src = chain_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) chain_q[s] <= RST_VAL;
      else         chain_q[s] <= src;
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/spi_sr_frame.sv
module spi_sr_frame
  import spi_sr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_ni,
  input  logic       cs_n_i,
  input  logic       sck_i,
  input  logic       mosi_i,
  input  logic [7:0] status_i,
  output logic       miso_o,
  output logic       miso_oe_o,
  output logic [7:0] op_o,
  output prot_t      wr_bits_o,
  output logic       frame_end_o,
  output logic       len_one_o,
  output logic       len_two_o
);
  logic       sck_q, cs_q;
  logic [7:0] rx_q, rx_d;
  logic [2:0] bit_q, bit_d;
  logic [1:0] byte_q, byte_d;
  logic [7:0] op_q, op_d;
  prot_t      wr_q, wr_d;
  logic [7:0] tx_q, tx_d;
  logic       oe_q, oe_d;
  logic       rise, fall, rx_en, tx_en;
  logic [7:0] rx_next;

  assign rise    = sck_i & ~sck_q & ~cs_n_i;
  assign fall    = ~sck_i & sck_q & ~cs_n_i;
  assign rx_next = {rx_q[6:0], mosi_i};

  always_comb begin
    rx_d   = rx_q;
    bit_d  = bit_q;
    byte_d = byte_q;
    op_d   = op_q;
    wr_d   = wr_q;
    tx_d   = tx_q;
    oe_d   = oe_q;
    rx_en  = 1'b0;
    tx_en  = 1'b0;
    if (cs_n_i) begin
      bit_d  = '0;
      byte_d = '0;
      oe_d   = 1'b0;
    end else if (rise) begin
      rx_en = 1'b1;
      rx_d  = rx_next;
      bit_d = bit_q + 3'd1;
      if (bit_q == 3'd7) begin
        if (byte_q != 2'd3) byte_d = byte_q + 2'd1;
        if (byte_q == 2'd0) op_d = rx_next;
        if (byte_q == 2'd1) wr_d = '{wpe: rx_next[7], bp: rx_next[3:2]};
      end
    end else if (fall) begin
      tx_en = 1'b1;
      if (op_q == OP_READ_STAT && byte_q != 2'd0 && bit_q == 3'd0) begin
        tx_d = status_i;
        oe_d = 1'b1;
      end else if (oe_q) begin
        tx_d = {tx_q[6:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q  <= 1'b0;
      cs_q   <= 1'b1;
      rx_q   <= '0;
      bit_q  <= '0;
      byte_q <= '0;
      op_q   <= '0;
      wr_q   <= '0;
      tx_q   <= '0;
      oe_q   <= 1'b0;
    end else begin
      sck_q  <= sck_i;
      cs_q   <= cs_n_i;
      bit_q  <= bit_d;
      byte_q <= byte_d;
      oe_q   <= oe_d;
      if (rx_en) begin
        rx_q <= rx_d;
        op_q <= op_d;
        wr_q <= wr_d;
      end
      if (tx_en) tx_q <= tx_d;
    end
  end

  assign miso_o      = tx_q[7];
  assign miso_oe_o   = oe_q;
  assign op_o        = op_q;
  assign wr_bits_o   = wr_q;
  assign frame_end_o = cs_n_i & ~cs_q;
  assign len_one_o   = (byte_q == 2'd1) && (bit_q == 3'd0);
  assign len_two_o   = (byte_q == 2'd2) && (bit_q == 3'd0);
endmodule

// File: rtl/spi_sr_regs.sv
module spi_sr_regs
  import spi_sr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_ni,
  input  logic       frame_end_i,
  input  logic [7:0] op_i,
  input  prot_t      wr_bits_i,
  input  logic       len_one_i,
  input  logic       len_two_i,
  input  logic       wp_n_i,
  input  logic       busy_i,
  output logic [7:0] status_o,
  output prot_t      prot_o,
  output logic       wel_o
);
  prot_t prot_q, prot_d;
  logic  wel_q, wel_d;
  logic  wren_done, wrsr_done, pin_lock;

  assign wren_done = frame_end_i && op_i == OP_SET_WEL    && len_one_i;
  assign wrsr_done = frame_end_i && op_i == OP_WRITE_STAT && len_two_i;
  assign pin_lock  = prot_q.wpe & ~wp_n_i;

  always_comb begin
    prot_d = prot_q;
    wel_d  = wel_q;
    if (wren_done) wel_d = 1'b1;
    if (wrsr_done) begin
      wel_d = 1'b0;
      if (wel_q && !pin_lock) prot_d = wr_bits_i;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      prot_q <= '0;
      wel_q  <= 1'b0;
    end else if (frame_end_i) begin
      prot_q <= prot_d;
      wel_q  <= wel_d;
    end
  end

  assign status_o = pack_status(prot_q, wel_q, busy_i);
  assign prot_o   = prot_q;
  assign wel_o    = wel_q;
endmodule

// File: rtl/spi_status_unit.sv
module spi_status_unit
  import spi_sr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sck,
  input  logic       mosi,
  output logic       miso,
  output logic       miso_oe,
  input  logic       wp_n,
  input  logic       busy,
  output logic [1:0] bp,
  output logic       wpe
);
  localparam int NSIG = 5;
  localparam logic [NSIG-1:0] PIN_IDLE = 5'b1_0_0_1_0; // cs_n, sck, mosi, wp_n, busy

  logic [1:0]      rst_pipe;
  logic            rst_sn;
  logic [NSIG-1:0] pins_s;
  logic            cs_n_s, sck_s, mosi_s, wp_n_s, busy_s;
  logic [7:0]      op, status;
  prot_t           wr_bits, prot;
  logic            frame_end, len_one, len_two, wel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  spi_sr_sync #(.WIDTH(NSIG), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) i_sync (
    .clk    (clk),
    .rst_ni (rst_sn),
    .d_i    ({cs_n, sck, mosi, wp_n, busy}),
    .q_o    (pins_s)
  );
  assign {cs_n_s, sck_s, mosi_s, wp_n_s, busy_s} = pins_s;

  spi_sr_frame i_frame (
    .clk         (clk),
    .rst_ni      (rst_sn),
    .cs_n_i      (cs_n_s),
    .sck_i       (sck_s),
    .mosi_i      (mosi_s),
    .status_i    (status),
    .miso_o      (miso),
    .miso_oe_o   (miso_oe),
    .op_o        (op),
    .wr_bits_o   (wr_bits),
    .frame_end_o (frame_end),
    .len_one_o   (len_one),
    .len_two_o   (len_two)
  );

  spi_sr_regs i_regs (
    .clk         (clk),
    .rst_ni      (rst_sn),
    .frame_end_i (frame_end),
    .op_i        (op),
    .wr_bits_i   (wr_bits),
    .len_one_i   (len_one),
    .len_two_i   (len_two),
    .wp_n_i      (wp_n_s),
    .busy_i      (busy_s),
    .status_o    (status),
    .prot_o      (prot),
    .wel_o       (wel)
  );

  assign bp  = prot.bp;
  assign wpe = prot.wpe;
endmodule

// File: rtl/spi_status_unit_chk.sv
module spi_status_unit_chk (
  input logic       clk,
  input logic       rst_sn,
  input logic       cs_n_s,
  input logic       miso_oe,
  input logic       frame_end,
  input logic       wel,
  input logic       wp_n_s,
  input logic [1:0] bp,
  input logic       wpe
);
  // R3: driver released once select is seen high
  a_r3_release_on_deselect: assert property (@(posedge clk) disable iff (!rst_sn)
    cs_n_s |=> !miso_oe);

  // R6: with the latch clear, the protection fields hold
  a_r6_locked_hold: assert property (@(posedge clk) disable iff (!rst_sn)
    !wel |=> $stable({bp, wpe}));

  // R9: pin guard active keeps the protection fields
  a_r9_pin_guard: assert property (@(posedge clk) disable iff (!rst_sn)
    (wpe && !wp_n_s) |=> $stable({bp, wpe}));

  // R4: latch can only rise at a frame end
  a_r4_wel_set_at_end: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(wel) |-> $past(frame_end));

  // R8: latch can only fall at a frame end
  a_r8_wel_clear_at_end: assert property (@(posedge clk) disable iff (!rst_sn)
    $fell(wel) |-> $past(frame_end));

  // R11: outputs move only at a frame end
  a_r11_prot_at_end: assert property (@(posedge clk) disable iff (!rst_sn)
    !$stable({bp, wpe}) |-> $past(frame_end));
endmodule

bind spi_status_unit spi_status_unit_chk i_chk (
  .clk       (clk),
  .rst_sn    (rst_sn),
  .cs_n_s    (cs_n_s),
  .miso_oe   (miso_oe),
  .frame_end (frame_end),
  .wel       (wel),
  .wp_n_s    (wp_n_s),
  .bp        (bp),
  .wpe       (wpe)
);

// File: tb/test_spi_status_unit.sv
module test_spi_status_unit;
  logic clk = 1'b0;
  logic rst_n, cs_n, sck, mosi, wp_n, busy;
  logic miso, miso_oe, wpe;
  logic [1:0] bp;
  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  spi_status_unit i_spi_status_unit (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .wp_n(wp_n), .busy(busy),
    .bp(bp), .wpe(wpe)
  );

  // {opcode, data, clock count, expected status afterwards}
  localparam int NV = 11;
  localparam logic [28:0] VEC [NV] = '{
    {8'h01, 8'h8C, 5'd16, 8'h00},  // R6 no latch
    {8'h06, 8'h00, 5'd8,  8'h02},  // R4
    {8'h01, 8'hFF, 5'd16, 8'h8C},  // R5 R8
    {8'h06, 8'h00, 5'd8,  8'h8E},  // R4
    {8'h01, 8'h04, 5'd12, 8'h8E},  // R7 short
    {8'h01, 8'h04, 5'd17, 8'h8E},  // R7 long
    {8'h01, 8'h08, 5'd16, 8'h08},  // R5 R8
    {8'h06, 8'h00, 5'd7,  8'h08},  // R7 short enable
    {8'h06, 8'h00, 5'd9,  8'h08},  // R7 long enable
    {8'h06, 8'h00, 5'd8,  8'h0A},  // R4
    {8'h01, 8'h73, 5'd16, 8'h00}   // R5 ignored bits, R10
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic half();
    repeat (8) @(negedge clk);
  endtask

  // shifts n bits of frame MSB first; captures miso and oe before each rise
  task automatic xfer(input logic [23:0] frame, input int n,
                      output logic [23:0] rx, output logic [23:0] oe);
    rx = '0; oe = '0;
    @(negedge clk); cs_n = 1'b0;
    half();
    for (int i = 0; i < n; i++) begin
      mosi = frame[23-i];
      half();
      rx[23-i] = miso;
      oe[23-i] = miso_oe;
      sck = 1'b1;
      half();
      sck = 1'b0;
    end
    half();
    cs_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic cmd(input logic [7:0] op, input logic [7:0] d, input int n);
    logic [23:0] r, e;
    xfer({op, d, 8'h00}, n, r, e);
  endtask

  task automatic read_stat(input logic [7:0] exp, input string req);
    logic [23:0] r, e;
    xfer({8'h05, 16'h0000}, 16, r, e);
    check(r[15:8] == exp, req, r[15:8], exp);
    check(e[23:16] == 8'h00 && e[15:8] == 8'hFF, "R3", e[23:8], 16'h00FF);
    check(bp == exp[3:2] && wpe == exp[7], "R11", {wpe, bp}, {exp[7], exp[3:2]});
  endtask

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; mosi = 1'b0; wp_n = 1'b1; busy = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check(miso_oe == 1'b0, "R1", miso_oe, 0);
    read_stat(8'h00, "R1");

    for (int v = 0; v < NV; v++) begin
      cmd(VEC[v][28:21], VEC[v][20:13], int'(VEC[v][12:8]));
      read_stat(VEC[v][7:0], "R5/R6/R7 table R2");
    end

    // R10 busy reflected, R12 repeated byte
    busy = 1'b1;
    repeat (6) @(negedge clk);
    begin
      logic [23:0] r, e;
      xfer({8'h05, 16'h0000}, 24, r, e);
      check(r[15:8] == 8'h01, "R10", r[15:8], 8'h01);
      check(r[7:0] == 8'h01, "R12", r[7:0], 8'h01);
      check(e[7:0] == 8'hFF, "R12 oe", e[7:0], 8'hFF);
    end
    busy = 1'b0;
    repeat (6) @(negedge clk);

    // R9 pin guard
    cmd(8'h06, 8'h00, 8); cmd(8'h01, 8'h80, 16);
    read_stat(8'h80, "R9 setup");
    wp_n = 1'b0;
    repeat (6) @(negedge clk);
    cmd(8'h06, 8'h00, 8); cmd(8'h01, 8'h0C, 16);
    read_stat(8'h80, "R9 refused R8");
    wp_n = 1'b1;
    repeat (6) @(negedge clk);
    cmd(8'h06, 8'h00, 8); cmd(8'h01, 8'h00, 16);
    read_stat(8'h00, "R9 released");
    wp_n = 1'b0;
    repeat (6) @(negedge clk);
    cmd(8'h06, 8'h00, 8); cmd(8'h01, 8'h04, 16);
    read_stat(8'h04, "R9 pin inert");
    wp_n = 1'b1;

    // R1 reset clears stored state
    cmd(8'h06, 8'h00, 8);
    read_stat(8'h06, "R4");
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check(bp == 2'b00 && wpe == 1'b0 && miso_oe == 1'b0, "R1", {wpe, bp, miso_oe}, 0);
    read_stat(8'h00, "R1");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule